// File: doc/BRIEF.md
# Polled RS485 Request/Reply Master

This block is the master end of a half-duplex RS485 link that polls slave boards one exchange at a time. A host hands it the payload of one request. The block builds a fixed-length frame and shifts it out through a byte-wide 8N1 serial transmitter, with the line driver enabled only while it sends. It then releases the line and waits for a reply frame of the same length.

The reply must open with the frame delimiter and carry a matching CRC-8 in its last byte. A reply fails if it is missing, stalls too long, has the wrong delimiter or has a bad CRC. Each such failure counts as one failed attempt, and the block sends the same request again, up to a set number of retries. The outcome returns to the host as one response beat. The beat holds a success flag, the number of failed attempts and the last frame received.

Both host-side interfaces use valid/ready. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the response has been consumed. The response beat stays valid, with all its fields frozen, until the host raises `rsp_ready`. The serial pins carry no handshake.

Top module: `rs485_poll_master`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `rsp_valid` is 0, `de_o` is 0 and `tx_o` is 1.
- R2: A request frame is FRAME_BYTES (28) bytes, each sent as 8N1, least significant bit first, at CLK_HZ/BAUD clocks per bit. Byte 0 is 0x40. Byte k, for k from 1 to 26, is `req_payload[8(k-1)+7 : 8(k-1)]`.
- R3: Byte 27 of the frame is a CRC-8 over bytes 0 to 26. It uses polynomial 0x07 and seed 0xFF, processes bits most significant first, and has no reflection and no final XOR.
- R4: `de_o` is high for the whole of each outgoing frame and low while a reply is awaited. Whenever `de_o` is low, `tx_o` is 1.
- R5: A reply whose byte 0 is 0x40 and whose byte 27 equals the R3 CRC of its bytes 0 to 26 ends the call. The response then has `rsp_ok`=1, `rsp_fail_cnt` equal to the number of earlier failed attempts, and the reply's byte k in `rsp_frame[8k+7:8k]`.
- R6: If no reply byte arrives within TIMEOUT_US microseconds of clock time, the attempt fails. The window is measured from the end of the request, or from the previous reply byte.
- R7: A complete reply with a wrong delimiter or a wrong CRC makes the attempt fail.
- R8: A failed attempt resends the identical frame, up to MAX_RETRY (2) times. If the last attempt also fails, the response has `rsp_ok`=0 and `rsp_fail_cnt`=MAX_RETRY+1, and no further frame is sent.
- R9: `req_ready` is low from the accepted request until the response is taken. A response held with `rsp_ready` low keeps `rsp_valid`, `rsp_ok` and `rsp_fail_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request payload offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_payload | input | (FRAME_BYTES-2)*8 | Payload bytes 1..26 of the frame |
| rsp_valid | output | 1 | Call outcome available |
| rsp_ready | input | 1 | Host takes the outcome |
| rsp_ok | output | 1 | 1 when a good reply was received |
| rsp_fail_cnt | output | clog2(MAX_RETRY+2) | Number of failed attempts |
| rsp_frame | output | FRAME_BYTES*8 | Last received reply frame |
| tx_o | output | 1 | Serial data to the transceiver |
| de_o | output | 1 | Transceiver drive enable |
| rx_i | input | 1 | Serial data from the transceiver |

## Verification
The hardest case to reach is the stalled reply. Some reply bytes arrive, the sender then goes silent, and the restarted byte timer must expire in the middle of a frame. The bench model of the slave stops after ten good bytes. It then waits for the retransmission and answers it properly, so the call must end with success and exactly one failed attempt. A second hard case is the spent retry budget, where the bench must also show that no fourth frame follows. It stays silent through three frames, then watches the driver enable for a long quiet interval after the failure response.

// File: rtl/rs485_poll_pkg.sv
package rs485_poll_pkg;
  localparam logic [7:0] FRAME_DELIM = 8'h40;
  localparam logic [7:0] CRC_POLY    = 8'h07;
  localparam logic [7:0] CRC_SEED    = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SEND, ST_LISTEN, ST_JUDGE, ST_REPORT
  } link_state_t;

  // one byte through the CRC register, most significant bit first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ CRC_POLY;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/rs485_byte_tx.sv
module rs485_byte_tx #(
  parameter int BIT_CLKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  output logic       line,
  output logic       busy,
  output logic       done
);
  localparam int CW = $clog2(BIT_CLKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(BIT_CLKS - 1);

  logic [9:0]    shreg;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      bitn  <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          shreg <= {1'b1, data, 1'b0};
          busy  <= 1'b1;
          cnt   <= '0;
          bitn  <= '0;
        end
      end else if (cnt == CNT_LAST) begin
        cnt <= '0;
        if (bitn == 4'd9) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bitn  <= bitn + 4'd1;
          shreg <= {1'b1, shreg[9:1]};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign line = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/rs485_byte_rx.sv
module rs485_byte_rx #(
  parameter int BIT_CLKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       line,
  output logic       valid,
  output logic [7:0] data
);
  localparam int CW   = $clog2(BIT_CLKS + 1);
  localparam int HALF = (BIT_CLKS / 2 > 0) ? BIT_CLKS / 2 : 1;
  localparam logic [CW-1:0] FULL_LAST = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  logic          s1, s2, active;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      bitn   <= '0;
      cnt    <= '0;
      sh     <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!en) begin
        active <= 1'b0;
      end else if (!active) begin
        if (!s2) begin
          active <= 1'b1;
          cnt    <= '0;
          bitn   <= '0;
        end
      end else if (cnt == ((bitn == 4'd0) ? HALF_LAST : FULL_LAST)) begin
        cnt <= '0;
        if (bitn == 4'd0) begin
          if (s2) active <= 1'b0;
          else    bitn <= 4'd1;
        end else if (bitn <= 4'd8) begin
          sh   <= {s2, sh[7:1]};
          bitn <= bitn + 4'd1;
        end else begin
          active <= 1'b0;
          valid  <= s2;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign data = sh;
endmodule

// File: rtl/rs485_poll_master.sv
module rs485_poll_master
  import rs485_poll_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BAUD        = 250_000,
  parameter int TIMEOUT_US  = 2000,
  parameter int FRAME_BYTES = 28,
  parameter int MAX_RETRY   = 2,
  localparam int PAYLOAD_W  = (FRAME_BYTES - 2) * 8,
  localparam int FW         = $clog2(MAX_RETRY + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [PAYLOAD_W-1:0]     req_payload,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic                     rsp_ok,
  output logic [FW-1:0]            rsp_fail_cnt,
  output logic [FRAME_BYTES*8-1:0] rsp_frame,
  output logic                     tx_o,
  output logic                     de_o,
  input  logic                     rx_i
);
  localparam int BIT_CLKS     = CLK_HZ / BAUD;
  localparam int TIMEOUT_CLKS = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int IW           = $clog2(FRAME_BYTES);
  localparam int TW           = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [IW-1:0] LAST_IDX   = IW'(FRAME_BYTES - 1);
  localparam logic [TW-1:0] TO_LAST    = TW'(TIMEOUT_CLKS - 1);
  localparam logic [FW-1:0] RETRY_LAST = FW'(MAX_RETRY);

  link_state_t              state;
  logic [PAYLOAD_W-1:0]     payload_q;
  logic [FW-1:0]            fails;
  logic [IW-1:0]            tx_idx, rx_idx, pidx;
  logic [7:0]               crc_tx, crc_rx, tx_byte, rx_byte;
  logic [TW-1:0]            timer;
  logic [FRAME_BYTES*8-1:0] rx_frame;
  logic                     ok_q, tx_start, tx_busy, tx_done, rx_valid;
  logic                     frame_good, attempt_fail;

  assign pidx = tx_idx - 1'b1;

  always_comb begin
    if (tx_idx == '0)            tx_byte = FRAME_DELIM;
    else if (tx_idx == LAST_IDX) tx_byte = crc_tx;
    else                         tx_byte = payload_q[pidx*8 +: 8];
  end

  assign tx_start     = (state == ST_SEND) && !tx_busy && !tx_done;
  assign frame_good   = (rx_frame[7:0] == FRAME_DELIM) &&
                        (rx_frame[LAST_IDX*8 +: 8] == crc_rx);
  assign attempt_fail = ((state == ST_LISTEN) && !rx_valid && (timer == TO_LAST)) ||
                        ((state == ST_JUDGE) && !frame_good);

  rs485_byte_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .data(tx_byte),
    .line(tx_o), .busy(tx_busy), .done(tx_done)
  );

  rs485_byte_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(state == ST_LISTEN), .line(rx_i),
    .valid(rx_valid), .data(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      payload_q <= '0;
      fails     <= '0;
      tx_idx    <= '0;
      rx_idx    <= '0;
      crc_tx    <= CRC_SEED;
      crc_rx    <= CRC_SEED;
      timer     <= '0;
      rx_frame  <= '0;
      ok_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          payload_q <= req_payload;
          fails     <= '0;
          state     <= ST_LOAD;
        end
        ST_LOAD: begin
          tx_idx <= '0;
          rx_idx <= '0;
          crc_tx <= CRC_SEED;
          crc_rx <= CRC_SEED;
          timer  <= '0;
          state  <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_start && tx_idx != LAST_IDX) crc_tx <= crc8_step(crc_tx, tx_byte);
          if (tx_done) begin
            if (tx_idx == LAST_IDX) state <= ST_LISTEN;
            else                    tx_idx <= tx_idx + 1'b1;
          end
        end
        ST_LISTEN: begin
          if (rx_valid) begin
            rx_frame[rx_idx*8 +: 8] <= rx_byte;
            if (rx_idx != LAST_IDX) crc_rx <= crc8_step(crc_rx, rx_byte);
            timer <= '0;
            if (rx_idx == LAST_IDX) state <= ST_JUDGE;
            else                    rx_idx <= rx_idx + 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_JUDGE: if (frame_good) begin
          ok_q  <= 1'b1;
          state <= ST_REPORT;
        end
        ST_REPORT: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (attempt_fail) begin
        fails <= fails + 1'b1;
        if (fails == RETRY_LAST) begin
          ok_q  <= 1'b0;
          state <= ST_REPORT;
        end else begin
          state <= ST_LOAD;
        end
      end
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign rsp_valid    = (state == ST_REPORT);
  assign rsp_ok       = ok_q;
  assign rsp_fail_cnt = fails;
  assign rsp_frame    = rx_frame;
  assign de_o         = (state == ST_SEND);
endmodule

// File: rtl/rs485_poll_chk.sv
module rs485_poll_chk #(
  parameter int MAX_RETRY = 2,
  localparam int FW = $clog2(MAX_RETRY + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_ok,
  input logic [FW-1:0] rsp_fail_cnt,
  input logic          tx_o,
  input logic          de_o
);
  localparam logic [FW-1:0] GIVE_UP = FW'(MAX_RETRY + 1);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok) && $stable(rsp_fail_cnt));

  // R9
  idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !de_o);

  // R4
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> tx_o);

  // R8
  give_up_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> rsp_fail_cnt == GIVE_UP);

  // R5
  success_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok |-> rsp_fail_cnt < GIVE_UP);

  // R4
  no_drive_while_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !de_o);
endmodule

bind rs485_poll_master rs485_poll_chk #(.MAX_RETRY(MAX_RETRY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_fail_cnt(rsp_fail_cnt),
  .tx_o(tx_o), .de_o(de_o)
);

// File: tb/sim_rs485_poll_master.sv
module sim_rs485_poll_master;
  localparam int FB   = 28;
  localparam int BITC = 4;
  localparam int PW   = (FB - 2) * 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [PW-1:0]  req_payload = '0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b0;
  logic           rsp_ok;
  logic [1:0]     rsp_fail_cnt;
  logic [FB*8-1:0] rsp_frame;
  logic           tx_o, de_o;
  logic           rx_i = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] cap[FB];
  logic [7:0] first_cap[FB];
  logic [7:0] rep[FB];
  bit         cap_ok;
  bit         de_bad;

  always #4 clk = ~clk;

  rs485_poll_master #(
    .CLK_HZ(1_000_000), .BAUD(250_000), .TIMEOUT_US(600),
    .FRAME_BYTES(FB), .MAX_RETRY(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_payload(req_payload), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_ok(rsp_ok), .rsp_fail_cnt(rsp_fail_cnt), .rsp_frame(rsp_frame),
    .tx_o(tx_o), .de_o(de_o), .rx_i(rx_i)
  );

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_reply(input logic [7:0] delim, input int seed, input bit corrupt);
    logic [7:0] c;
    rep[0] = delim;
    for (int k = 1; k < FB - 1; k++) rep[k] = 8'(seed + 13 * k);
    c = 8'hFF;
    for (int k = 0; k < FB - 1; k++) c = ref_crc(c, rep[k]);
    rep[FB-1] = corrupt ? (c ^ 8'h01) : c;
  endtask

  task automatic issue(input logic [PW-1:0] p);
    @(negedge clk);
    req_payload = p;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low after accept", req_ready, 0);
  endtask

  task automatic capture();
    cap_ok = 1;
    de_bad = 0;
    for (int b = 0; b < FB; b++) begin
      int wait_n;
      wait_n = 0;
      @(negedge clk);
      while (tx_o !== 1'b0 && wait_n < 4000) begin
        @(negedge clk);
        wait_n++;
      end
      if (wait_n >= 4000) begin
        cap_ok = 0;
        return;
      end
      repeat (BITC / 2) @(negedge clk);
      if (de_o !== 1'b1) de_bad = 1;
      for (int i = 0; i < 8; i++) begin
        repeat (BITC) @(negedge clk);
        cap[b][i] = tx_o;
        if (de_o !== 1'b1) de_bad = 1;
      end
      repeat (BITC) @(negedge clk);
      if (de_o !== 1'b1 || tx_o !== 1'b1) de_bad = 1;
    end
  endtask

  task automatic send_bytes(input int n);
    for (int b = 0; b < n; b++) begin
      rx_i = 1'b0;
      repeat (BITC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        rx_i = rep[b][i];
        repeat (BITC) @(negedge clk);
      end
      rx_i = 1'b1;
      repeat (BITC + 1) @(negedge clk);
    end
  endtask

  task automatic wait_rsp(output bit got);
    int n;
    n = 0;
    while (rsp_valid !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    got = (rsp_valid === 1'b1);
  endtask

  task automatic take_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 response consumed", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic check_frame(input logic [PW-1:0] p, input string tag);
    logic [7:0] c;
    bit pay_ok;
    chk(cap_ok, {tag, " R2 frame seen"}, cap_ok, 1);
    chk(cap[0] == 8'h40, {tag, " R2 delimiter"}, cap[0], 8'h40);
    pay_ok = 1;
    for (int k = 1; k < FB - 1; k++) if (cap[k] != p[8*(k-1) +: 8]) pay_ok = 0;
    chk(pay_ok, {tag, " R2 payload bytes"}, pay_ok, 1);
    c = 8'hFF;
    for (int k = 0; k < FB - 1; k++) c = ref_crc(c, cap[k]);
    chk(cap[FB-1] == c, {tag, " R3 crc byte"}, cap[FB-1], c);
    chk(!de_bad, {tag, " R4 drive enable over frame"}, de_bad, 0);
  endtask

  function automatic logic [PW-1:0] make_payload(input int seed);
    logic [PW-1:0] p;
    for (int k = 0; k < FB - 2; k++) p[8*k +: 8] = 8'(seed * 7 + 31 * k);
    return p;
  endfunction

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(de_o == 1'b0 && tx_o == 1'b1, "R1 line idle", {de_o, tx_o}, 2'b01);
  endtask

  task automatic t_first_try();
    logic [PW-1:0] p;
    bit got, same;
    logic [1:0] f0;
    p = make_payload(3);
    issue(p);
    capture();
    check_frame(p, "first_try");
    repeat (8) @(negedge clk);
    chk(de_o == 1'b0, "R4 driver released for reply", de_o, 0);
    build_reply(8'h40, 5, 0);
    send_bytes(FB);
    wait_rsp(got);
    chk(got && rsp_ok == 1'b1, "R5 success flag", rsp_ok, 1);
    chk(rsp_fail_cnt == 2'd0, "R5 zero failed attempts", rsp_fail_cnt, 0);
    same = 1;
    for (int k = 0; k < FB; k++) if (rsp_frame[8*k +: 8] != rep[k]) same = 0;
    chk(same, "R5 reply frame returned", same, 1);
    f0 = rsp_fail_cnt;
    repeat (20) @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_ok == 1'b1 && rsp_fail_cnt == f0, "R9 response held",
        {rsp_valid, rsp_ok}, 2'b11);
    chk(req_ready == 1'b0, "R9 no new request while holding", req_ready, 0);
    take_rsp();
  endtask

  task automatic t_all_timeouts();
    logic [PW-1:0] p;
    bit got, same, quiet;
    p = make_payload(9);
    issue(p);
    capture();
    check_frame(p, "timeout_a1");
    first_cap = cap;
    for (int a = 1; a < 3; a++) begin
      capture();
      same = cap_ok;
      for (int k = 0; k < FB; k++) if (cap[k] != first_cap[k]) same = 0;
      chk(same, "R8 R6 identical resend after silence", same, 1);
    end
    wait_rsp(got);
    chk(got && rsp_ok == 1'b0, "R8 failure flag", rsp_ok, 0);
    chk(rsp_fail_cnt == 2'd3, "R8 three failed attempts", rsp_fail_cnt, 3);
    quiet = 1;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (de_o !== 1'b0) quiet = 0;
    end
    chk(quiet, "R8 no fourth frame", quiet, 1);
    take_rsp();
  endtask

  task automatic t_bad_crc_then_ok();
    logic [PW-1:0] p;
    bit got;
    p = make_payload(21);
    issue(p);
    capture();
    check_frame(p, "badcrc_a1");
    repeat (8) @(negedge clk);
    build_reply(8'h40, 40, 1);
    send_bytes(FB);
    capture();
    check_frame(p, "R7 retry after bad crc");
    repeat (8) @(negedge clk);
    build_reply(8'h40, 41, 0);
    send_bytes(FB);
    wait_rsp(got);
    chk(got && rsp_ok == 1'b1, "R7 success on second attempt", rsp_ok, 1);
    chk(rsp_fail_cnt == 2'd1, "R7 one failed attempt", rsp_fail_cnt, 1);
    take_rsp();
  endtask

  task automatic t_bad_delim();
    logic [PW-1:0] p;
    bit got;
    p = '1;
    issue(p);
    for (int a = 0; a < 3; a++) begin
      capture();
      check_frame(p, "R7 bad delimiter attempt");
      repeat (8) @(negedge clk);
      build_reply(8'h41, 60 + a, 0);
      send_bytes(FB);
    end
    wait_rsp(got);
    chk(got && rsp_ok == 1'b0 && rsp_fail_cnt == 2'd3, "R7 R8 delimiter rejected thrice",
        {rsp_ok, rsp_fail_cnt}, 3'b011);
    take_rsp();
  endtask

  task automatic t_stall();
    logic [PW-1:0] p;
    bit got;
    p = '0;
    issue(p);
    capture();
    check_frame(p, "stall_a1");
    repeat (8) @(negedge clk);
    build_reply(8'h40, 77, 0);
    send_bytes(10);
    capture();
    check_frame(p, "R6 retry after stalled reply");
    repeat (8) @(negedge clk);
    build_reply(8'h40, 78, 0);
    send_bytes(FB);
    wait_rsp(got);
    chk(got && rsp_ok == 1'b1 && rsp_fail_cnt == 2'd1, "R6 stall counted once",
        {rsp_ok, rsp_fail_cnt}, 3'b101);
    take_rsp();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_try();
    t_all_timeouts();
    t_bad_crc_then_ok();
    t_bad_delim();
    t_stall();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule